// File: doc/BRIEF.md
# Multi-Threshold Switch Zone Classifier

This block sorts a stream of 10-bit converter readings into switch zones. Each reading arrives with an input number from 0 to 23. The block compares the reading against the set of threshold codes that belongs to that input and keeps one above/below bit per threshold for each input. It reports the zone of every input, which is the number of thresholds that the latest reading met. When a reading changes the bit of a threshold whose interrupt is enabled, the block marks the input as pending and raises a level interrupt.

Inputs fall into four groups, each with its own threshold set:
- Inputs 0 to 11 each pick one of eight general thresholds, and they all share one common threshold as a second check.
- Inputs 12 to 17 share a pair of thresholds.
- Inputs 18 to 22 share three thresholds.
- Input 23 uses those three thresholds plus two upper thresholds of its own.

Software programs the threshold codes, the per-input selectors and a per-threshold interrupt enable mask through a simple write port. When several thresholds are set to the same code and only the highest one is enabled, a multi-threshold input acts as a single-threshold digital switch.

Top module: `zone_classifier`

## Requirements
- R1: A reading meets a threshold when its code is greater than or equal to the threshold code. The zone of an input is the number of its thresholds that its latest reading met.
- R2: Each of inputs 0 to 11 compares against two thresholds. The first is the general threshold chosen by that input's 3-bit selector (threshold ids 0 to 7). The second is the common threshold (id 8). The zone of these inputs is 0, 1 or 2.
- R3: Inputs 12 to 17 use ids 9 and 10, so their zone is 0 to 2. Inputs 18 to 22 use ids 11, 12 and 13, so their zone is 0 to 3. Input 23 uses ids 11, 12, 13, 14 and 15, so its zone is 0 to 5.
- R4: The first reading an input receives after reset only loads that input's bits. It never sets the input's pending flag.
- R5: A later reading sets an input's pending flag only if some threshold of that input changes its met/not-met bit and that threshold's enable bit (bit position = threshold id) is 1. A change at a disabled threshold is ignored.
- R6: `irq` is high while any pending flag is set. `irq_clr` clears every pending flag. If a reading sets a pending flag in the same cycle as a clear, that flag ends up set.
- R7: A reading whose input number is 24 to 31 changes no zone and no pending flag.
- R8: Register map (the data goes in the low bits of `cfg_wdata`):
  - Addresses 0 to 15 take the 10-bit code of the threshold with that id.
  - Addresses 16 to 27 take the 3-bit selector of input (address − 16).
  - Address 28 takes the 16-bit enable mask.
  - All other addresses are ignored.
  A set of thresholds written out of order is stored exactly as written, and each threshold is still compared on its own.
- R9: After reset, every zone, every pending flag and `irq` are 0, all thresholds are 0, all selectors are 0 and all enables are 0. A reading accepted at a clock edge shows on the outputs just after that same edge.
- R10: A register write on its own changes no zone and no pending flag. New settings take effect only from the next reading of an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A reading is present this cycle |
| smp_idx | input | 5 | Input number of the reading |
| smp_code | input | 10 | Converter code of the reading |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 16 | Register write data |
| irq_clr | input | 1 | Pulse that clears all pending flags |
| zone_flat | output | 72 | Zone of input i in bits [3i+2:3i] |
| pend | output | 24 | Pending flag per input |
| irq | output | 1 | Level interrupt, the OR of all pending flags |

## Verification
The assertions check the following on every cycle:
- Each zone stays inside the range that its group allows.
- A clear with no reading drops the interrupt.
- Pending flags and zones hold when there is no reading.
- A first reading and an out-of-range input number leave the pending flags unchanged.
- A register write alone leaves the zones unchanged.

Only the bench scenarios can show the following:
- The exact zone values at the threshold boundaries.
- That the selector picks the right general threshold.
- That disabled thresholds are masked while enabled ones fire.
- That a crossing beats a clear in the same cycle.
- That thresholds written out of order and equal-code setups behave as specified.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int NUM_IN    = 24;
  localparam int NUM_THR   = 16;
  localparam int NUM_SEL   = 12;
  localparam int SLOTS     = 5;
  localparam int ZONE_W    = 3;
  localparam int SEL_W     = 3;
  localparam int TID_W     = $clog2(NUM_THR);
  localparam int IDX_W     = 5;

  localparam int TH_COMMON = 8;
  localparam int TH_PAIR   = 9;
  localparam int TH_TRIO   = 11;
  localparam int TH_UPPER  = 14;

  localparam int ADR_SEL   = 16;
  localparam int ADR_EN    = 28;

  typedef struct packed {
    logic             used;
    logic [TID_W-1:0] id;
  } slot_t;

  // Map (input, slot) onto a threshold id; slot order follows ascending thresholds.
  function automatic slot_t slot_map(input logic [IDX_W-1:0] idx, input int slot,
                                     input logic [SEL_W-1:0] selv);
    slot_t r;
    r.used = 1'b0;
    r.id   = '0;
    if (idx < IDX_W'(NUM_SEL)) begin
      if (slot == 0) begin
        r.used = 1'b1;
        r.id   = TID_W'(selv);
      end else if (slot == 1) begin
        r.used = 1'b1;
        r.id   = TID_W'(TH_COMMON);
      end
    end else if (idx < IDX_W'(18)) begin
      if (slot < 2) begin
        r.used = 1'b1;
        r.id   = TID_W'(TH_PAIR + slot);
      end
    end else if (idx < IDX_W'(23)) begin
      if (slot < 3) begin
        r.used = 1'b1;
        r.id   = TID_W'(TH_TRIO + slot);
      end
    end else if (idx == IDX_W'(23)) begin
      r.used = 1'b1;
      r.id   = (slot < 3) ? TID_W'(TH_TRIO + slot) : TID_W'(TH_UPPER + slot - 3);
    end
    return r;
  endfunction

  function automatic int zone_limit(input int i);
    if (i < 18)      return 2;
    else if (i < 23) return 3;
    else             return 5;
  endfunction
endpackage

// File: rtl/zc_regs.sv
module zc_regs
  import zc_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [NUM_THR-1:0][CODE_W-1:0]    thr,
  output logic [NUM_SEL-1:0][SEL_W-1:0]     sel,
  output logic [NUM_THR-1:0]                en
);
  localparam int SEL_IW = $clog2(NUM_SEL);

  logic [NUM_THR-1:0][CODE_W-1:0] thr_q, thr_d;
  logic [NUM_SEL-1:0][SEL_W-1:0]  sel_q, sel_d;
  logic [NUM_THR-1:0]             en_q, en_d;
  logic [ADDR_W-1:0]              sel_off;

  assign sel_off = addr - ADDR_W'(ADR_SEL);

  always_comb begin
    thr_d = thr_q;
    sel_d = sel_q;
    en_d  = en_q;
    if (addr < ADDR_W'(NUM_THR)) begin
      thr_d[addr[TID_W-1:0]] = wdata[CODE_W-1:0];
    end else if (addr >= ADDR_W'(ADR_SEL) && addr < ADDR_W'(ADR_SEL + NUM_SEL)) begin
      sel_d[sel_off[SEL_IW-1:0]] = wdata[SEL_W-1:0];
    end else if (addr == ADDR_W'(ADR_EN)) begin
      en_d = wdata[NUM_THR-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
      sel_q <= '0;
      en_q  <= '0;
    end else if (we) begin
      thr_q <= thr_d;
      sel_q <= sel_d;
      en_q  <= en_d;
    end
  end

  assign thr = thr_q;
  assign sel = sel_q;
  assign en  = en_q;
endmodule

// File: rtl/zc_compare.sv
module zc_compare
  import zc_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic [IDX_W-1:0]               idx,
  input  logic [CODE_W-1:0]              code,
  input  logic [NUM_THR-1:0][CODE_W-1:0] thr,
  input  logic [NUM_SEL-1:0][SEL_W-1:0]  sel,
  input  logic [NUM_THR-1:0]             en,
  output logic [SLOTS-1:0]               met,
  output logic [SLOTS-1:0]               cen
);
  localparam int SEL_IW = $clog2(NUM_SEL);

  logic [SEL_W-1:0] selv;

  assign selv = (idx < IDX_W'(NUM_SEL)) ? sel[idx[SEL_IW-1:0]] : '0;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    slot_t m;
    assign m      = slot_map(idx, g, selv);
    assign met[g] = m.used && (code >= thr[m.id]);
    assign cen[g] = m.used && en[m.id];
  end
endmodule

// File: rtl/zc_state.sv
module zc_state
  import zc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          take,
  input  logic [IDX_W-1:0]              idx,
  input  logic [SLOTS-1:0]              met,
  input  logic [SLOTS-1:0]              cen,
  input  logic                          clr,
  output logic [NUM_IN-1:0][ZONE_W-1:0] zone,
  output logic [NUM_IN-1:0]             pend
);
  logic [NUM_IN-1:0][SLOTS-1:0] bits_q, bits_d;
  logic [NUM_IN-1:0]            init_q, init_d;
  logic [NUM_IN-1:0]            pend_q, pend_d;
  logic [SLOTS-1:0]             hit;

  always_comb begin
    bits_d = bits_q;
    init_d = init_q;
    pend_d = clr ? '0 : pend_q;
    hit    = '0;
    if (take) begin
      hit         = (met ^ bits_q[idx]) & cen;
      bits_d[idx] = met;
      init_d[idx] = 1'b1;
      if (init_q[idx] && (|hit)) pend_d[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      init_q <= '0;
    end else if (take) begin
      bits_q <= bits_d;
      init_q <= init_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (take || clr) begin
      pend_q <= pend_d;
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_zone
    logic [ZONE_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int s = 0; s < SLOTS; s++) cnt = cnt + ZONE_W'(bits_q[i][s]);
    end
    assign zone[i] = cnt;
  end

  assign pend = pend_q;
endmodule

// File: rtl/zone_classifier.sv
module zone_classifier
  import zc_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic [IDX_W-1:0]         smp_idx,
  input  logic [CODE_W-1:0]        smp_code,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  input  logic                     irq_clr,
  output logic [NUM_IN*ZONE_W-1:0] zone_flat,
  output logic [NUM_IN-1:0]        pend,
  output logic                     irq
);
  logic [NUM_THR-1:0][CODE_W-1:0] thr;
  logic [NUM_SEL-1:0][SEL_W-1:0]  sel;
  logic [NUM_THR-1:0]             en;
  logic [SLOTS-1:0]               met, cen;
  logic [NUM_IN-1:0][ZONE_W-1:0]  zone;
  logic                           take;

  assign take = smp_valid && (smp_idx < IDX_W'(NUM_IN));

  zc_regs #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .thr(thr), .sel(sel), .en(en)
  );

  zc_compare #(.CODE_W(CODE_W)) u_cmp (
    .idx(smp_idx), .code(smp_code), .thr(thr), .sel(sel), .en(en),
    .met(met), .cen(cen)
  );

  zc_state u_state (
    .clk(clk), .rst_n(rst_n), .take(take), .idx(smp_idx), .met(met), .cen(cen),
    .clr(irq_clr), .zone(zone), .pend(pend)
  );

  assign zone_flat = zone;
  assign irq       = |pend;
endmodule

// File: rtl/zc_checker.sv
module zc_checker
  import zc_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     smp_valid,
  input logic [IDX_W-1:0]         smp_idx,
  input logic                     cfg_we,
  input logic                     irq_clr,
  input logic [NUM_IN*ZONE_W-1:0] zone_flat,
  input logic [NUM_IN-1:0]        pend,
  input logic                     irq
);
  logic [NUM_IN-1:0] seen_q;
  logic              in_range, first_hit, zone_ok;

  assign in_range  = smp_idx < IDX_W'(NUM_IN);
  assign first_hit = smp_valid && in_range && !seen_q[smp_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (smp_valid && in_range) seen_q[smp_idx] <= 1'b1;
  end

  always_comb begin
    zone_ok = 1'b1;
    for (int i = 0; i < NUM_IN; i++)
      if (zone_flat[i*ZONE_W +: ZONE_W] > ZONE_W'(zone_limit(i))) zone_ok = 1'b0;
  end

  p_zone_range_r3: assert property (@(posedge clk) disable iff (!rst_n) zone_ok)
    else $error("zone out of group range");

  p_first_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    first_hit && !irq_clr |=> $stable(pend))
    else $error("first reading raised a pending flag");

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !smp_valid |=> !irq)
    else $error("clear did not drop irq");

  p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid && !irq_clr |=> $stable(pend))
    else $error("pending changed without cause");

  p_bad_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !in_range && !irq_clr |=> $stable(pend) && $stable(zone_flat))
    else $error("out-of-range reading had an effect");

  p_write_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !smp_valid |=> $stable(zone_flat))
    else $error("register write moved a zone");
endmodule

bind zone_classifier zc_checker u_chk (.*);

// File: tb/zone_classifier_test.sv
`timescale 1ns/1ps
module zone_classifier_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid, cfg_we, irq_clr;
  logic [4:0]  smp_idx, cfg_addr;
  logic [9:0]  smp_code;
  logic [15:0] cfg_wdata;
  logic [71:0] zone_flat;
  logic [23:0] pend;
  logic        irq;

  int nchk = 0, nfail = 0;
  bit done = 0;

  int       m_thr[16];
  int       m_sel[12];
  bit [15:0] m_en;
  bit [4:0] m_bits[24];
  bit       m_init[24];
  bit [23:0] m_pend;

  zone_classifier uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_idx(smp_idx),
    .smp_code(smp_code), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .irq_clr(irq_clr), .zone_flat(zone_flat), .pend(pend), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Threshold id for (input, slot) per R2/R3, -1 when the slot is unused.
  function automatic int tid(int i, int s);
    case (1'b1)
      (i < 12): return (s == 0) ? m_sel[i] : (s == 1) ? 8 : -1;
      (i < 18): return (s < 2) ? 9 + s : -1;
      (i < 23): return (s < 3) ? 11 + s : -1;
      default:  return (s < 3) ? 11 + s : 11 + s;
    endcase
  endfunction

  // Behavioural reference updated on every clock edge.
  always @(posedge clk) begin
    bit [23:0] np;
    bit [4:0]  nb;
    bit        chg;
    int        ii, t, a;
    if (!rst_n) begin
      foreach (m_thr[k]) m_thr[k] = 0;
      foreach (m_sel[k]) m_sel[k] = 0;
      foreach (m_bits[k]) begin m_bits[k] = 0; m_init[k] = 0; end
      m_en = 0; m_pend = 0;
    end else begin
      np = irq_clr ? 24'h0 : m_pend;
      if (smp_valid && smp_idx < 24) begin
        ii = smp_idx; nb = 0; chg = 0;
        for (int s = 0; s < 5; s++) begin
          t = tid(ii, s);
          if (t >= 0) begin
            nb[s] = int'(smp_code) >= m_thr[t];
            if (nb[s] != m_bits[ii][s] && m_en[t]) chg = 1;
          end
        end
        if (m_init[ii] && chg) np[ii] = 1;
        m_bits[ii] = nb;
        m_init[ii] = 1;
      end
      if (cfg_we) begin
        a = cfg_addr;
        if (a < 16) m_thr[a] = int'(cfg_wdata[9:0]);
        else if (a < 28) m_sel[a-16] = int'(cfg_wdata[2:0]);
        else if (a == 28) m_en = cfg_wdata;
      end
      m_pend = np;
    end
  end

  always @(negedge clk) begin
    logic [71:0] ez;
    if (rst_n && !done) begin
      for (int i = 0; i < 24; i++) ez[i*3 +: 3] = 3'($countones(m_bits[i]));
      chk("R1 zone vector vs model", zone_flat, ez);
      chk("R5 pending vs model", pend, m_pend);
      chk("R6 irq vs model", irq, |m_pend);
    end
  end

  function automatic int zone_of(int i);
    return int'(zone_flat[i*3 +: 3]);
  endfunction

  task automatic smp(input int idx, input int code, input bit clr);
    smp_valid = 1; smp_idx = 5'(idx); smp_code = 10'(code); irq_clr = clr;
    @(negedge clk);
    smp_valid = 0; irq_clr = 0;
  endtask

  task automatic cfg(input int a, input int d);
    cfg_we = 1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clr_pulse();
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [71:0] snap;
    rst_n = 0; smp_valid = 0; cfg_we = 0; irq_clr = 0;
    smp_idx = 0; smp_code = 0; cfg_addr = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset zones", zone_flat, 0);
    chk("R9 reset pend", pend, 0);
    chk("R9 reset irq", irq, 0);

    for (int k = 0; k < 8; k++) cfg(k, 100 * (k + 1));
    cfg(8, 500); cfg(9, 300); cfg(10, 600);
    cfg(11, 200); cfg(12, 400); cfg(13, 700); cfg(14, 800); cfg(15, 900);
    for (int i = 0; i < 12; i++) cfg(16 + i, i % 8);
    cfg(28, 16'hFFFF);
    chk("R10 writes leave zones", zone_flat, 0);

    smp(0, 1023, 0);
    chk("R4 first reading zone", zone_of(0), 2);
    chk("R4 first reading no irq", irq, 0);
    for (int i = 1; i < 24; i++) smp(i, 0, 0);
    chk("R4 init pass no pending", pend, 0);

    smp(3, 450, 0);
    chk("R2 mapped only zone", zone_of(3), 1);
    chk("R5 enabled crossing pend", pend, 24'h000008);
    smp(3, 1023, 0);
    chk("R2 mapped plus common", zone_of(3), 2);

    clr_pulse();
    chk("R6 clear drops irq", irq, 0);
    smp(4, 550, 0);
    smp(5, 650, 1);
    chk("R6 crossing beats clear", pend, 24'h000020);
    clr_pulse();

    smp(12, 299, 0);
    chk("R1 below pair A", zone_of(12), 0);
    smp(12, 300, 0);
    chk("R1 equal to pair A", zone_of(12), 1);
    smp(12, 600, 0);
    chk("R3 pair top zone", zone_of(12), 2);
    smp(20, 700, 0);
    chk("R3 trio top zone", zone_of(20), 3);
    smp(23, 1023, 0);
    chk("R3 five thresholds top", zone_of(23), 5);
    smp(23, 899, 0);
    chk("R1 just below upper", zone_of(23), 4);
    smp(23, 900, 0);
    chk("R1 equal upper", zone_of(23), 5);

    clr_pulse();
    cfg(28, 16'hE7FF);
    smp(19, 250, 0);
    chk("R5 disabled crossing ignored", pend, 0);
    smp(19, 450, 0);
    chk("R5 second disabled ignored", pend, 0);
    smp(19, 750, 0);
    chk("R5 enabled top crossing", pend, 24'h080000);
    clr_pulse();
    cfg(11, 500); cfg(12, 500); cfg(13, 500);
    smp(21, 600, 0);
    chk("R5 equal codes zone", zone_of(21), 3);
    chk("R5 equal codes single switch", pend, 24'h200000);
    clr_pulse();

    snap = zone_flat;
    smp(27, 1023, 0);
    chk("R7 bad index zones", zone_flat, snap);
    chk("R7 bad index pend", pend, 0);

    cfg(9, 800); cfg(10, 100);
    smp(13, 500, 0);
    chk("R8 unordered pair zone", zone_of(13), 1);
    chk("R8 unordered pair pend", pend, 24'h002000);
    clr_pulse();

    cfg(3, 1000);
    chk("R10 threshold write zone", zone_of(3), 2);
    chk("R10 threshold write irq", irq, 0);
    smp(3, 950, 0);
    chk("R10 new threshold on reading", zone_of(3), 1);
    cfg(19, 7);
    smp(3, 950, 0);
    chk("R2 selector remap", zone_of(3), 2);

    for (int n = 0; n < 500; n++) begin
      int r;
      r = $urandom % 8;
      if (r == 0) cfg($urandom % 32, $urandom % 65536);
      else if (r == 1) clr_pulse();
      else smp($urandom % 32, $urandom % 1024, ($urandom % 6) == 0);
    end

    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule